// File: doc/BRIEF.md
# Receive Descriptor Writeback Engine

This block sits between a receive byte stream and system memory. It walks a linked list of receive descriptors, each four 32-bit words long: the status/length word at offset 0, the buffer start address at offset 4, an unused word at offset 8 and the link to the next descriptor at offset 12. For each descriptor the engine first reads the status word and continues only if the two-bit owner field in bits 31:30 holds the engine code 2'b10. It then reads the buffer address and the link, packs the incoming bytes into little-endian 32-bit words and writes them to consecutive buffer words. When the last byte has been stored, it writes the status word back with ownership returned to software.

Software enables reception with a level control, chooses whether frames longer than the normal maximum are kept, and gives the list head address. When the engine meets a descriptor it does not own, it parks. While parked it discards incoming frames and reports each one as a descriptor-unavailable event. A single-cycle kick pulse makes it fetch the same descriptor again. All events leave the block as single-cycle pulses.

Top module: `rxdwb_engine`

## Requirements
- R1: After reset, with reception off, no memory request is raised, all event pulses are low, the stream input is accepted (rx_ready high) and cur_desc_addr equals cfg_list_base.
- R2: The engine reads the status word at cur_desc_addr. Owner bits 31:30 equal to 2'b10 let it go on to read offsets 4 and 12. Any other owner value makes it park and pulse ev_unavail once.
- R3: Frame bytes are stored little-endian: byte k of the frame goes to buffer word k/4, bits 8*(k%4)+7:8*(k%4). Unused upper bytes of the final word are zero.
- R4: On completion the status word is written back at cur_desc_addr. Bits 31:30 become 2'b00, bit 20 (good frame) is set, and bits 15:0 hold the payload byte count plus 4.
- R5: Bit 16 of the written status word, and the ev_rxint pulse, appear only when cfg_rxint_en is set.
- R6: After the status writeback, cur_desc_addr takes the link read from offset 12, and ev_good pulses. ev_early pulses when the first data word of a frame has been written.
- R7: With cfg_accept_long set, a frame longer than MAX_FRAME bytes is stored in full. Its status word has both bit 19 and bit 20 set, and ev_too_long pulses together with ev_good.
- R8: With cfg_accept_long clear, an over-length frame is dropped. ev_too_long pulses, the descriptor status word is left unchanged and cur_desc_addr does not move. The next frame uses the same descriptor.
- R9: While parked, each incoming frame is consumed and discarded and ev_unavail pulses at its last byte. A kick makes the engine fetch the same descriptor again.
- R10: While cfg_rx_on is low, the engine makes no memory access, discards incoming frames and keeps cur_desc_addr equal to cfg_list_base.
- R11: Once raised, a memory request keeps its address and direction until mem_ack.
- R12: A frame of exactly MAX_FRAME bytes is not flagged too long (bit 19 clear, no ev_too_long).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_list_base | input | ADDR_W | Address of the first descriptor |
| cfg_rx_on | input | 1 | Reception enable |
| cfg_accept_long | input | 1 | Keep frames longer than MAX_FRAME |
| cfg_rxint_en | input | 1 | Global receive-interrupt enable |
| rx_kick | input | 1 | Pulse: retry a parked descriptor |
| rx_valid | input | 1 | Stream byte valid |
| rx_data | input | 8 | Stream byte |
| rx_last | input | 1 | Final byte of frame |
| rx_ready | output | 1 | Engine takes the byte this cycle |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Request completed |
| cur_desc_addr | output | ADDR_W | Current descriptor address |
| ev_good | output | 1 | Pulse: frame stored and descriptor released |
| ev_too_long | output | 1 | Pulse: frame exceeded MAX_FRAME |
| ev_early | output | 1 | Pulse: first data word of a frame written |
| ev_unavail | output | 1 | Pulse: descriptor not owned / frame discarded |
| ev_rxint | output | 1 | Pulse: receive interrupt |

## Verification
The bench builds the engine with MAX_FRAME set to 12. This puts the length boundary within frames of a dozen bytes, so the exact-limit case, the kept-long case and the dropped-long case all run in a few hundred cycles. The ADDR_W and LENW defaults are kept. The bench memory answers after a latency of zero or two cycles, set per scenario, so the request-hold rule sees both immediate and delayed acknowledgement.

// File: rtl/rxdwb_pkg.sv
package rxdwb_pkg;

    localparam int WORD_W     = 32;
    localparam int WORD_BYTES = WORD_W / 8;

    // descriptor layout (byte offsets)
    localparam int OFS_STATUS = 0;
    localparam int OFS_BUFFER = 4;
    localparam int OFS_LINK   = 12;

    // status word fields
    localparam int OWNER_HI  = 31;
    localparam int OWNER_LO  = 30;
    localparam int BIT_GOOD  = 20;
    localparam int BIT_LONG  = 19;
    localparam int BIT_INTR  = 16;
    localparam int CRC_BYTES = 4;

    localparam logic [1:0] OWNER_ENGINE = 2'b10;
    localparam logic [1:0] OWNER_CPU    = 2'b00;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_OWN,
        ST_BUF,
        ST_LINK,
        ST_RECV,
        ST_WDATA,
        ST_WSTAT,
        ST_DROP,
        ST_STALL
    } rx_state_e;

endpackage

// File: rtl/rxdwb_packer.sv
module rxdwb_packer
    import rxdwb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_i,
    input  logic [7:0]        byte_i,
    input  logic              last_i,
    input  logic              clr_i,
    output logic [WORD_W-1:0] word_o,
    output logic              full_o,
    output logic              last_o
);

    localparam int LANES = WORD_BYTES;
    localparam int LW    = $clog2(LANES);

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [LW-1:0]     lane;
        logic              full;
        logic              last;
    } pk_t;

    pk_t pk_d, pk_q;

    always_comb begin
        pk_d = pk_q;
        if (clr_i) begin
            pk_d = '0;
        end else if (take_i) begin
            for (int i = 0; i < LANES; i++) begin
                if (pk_q.lane == LW'(i)) begin
                    pk_d.word[i*8 +: 8] = byte_i;
                end
            end
            pk_d.lane = pk_q.lane + 1'b1;
            pk_d.full = last_i || (pk_q.lane == LW'(LANES - 1));
            pk_d.last = last_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pk_q <= '0;
        else        pk_q <= pk_d;
    end

    assign word_o = pk_q.word;
    assign full_o = pk_q.full;
    assign last_o = pk_q.last;

    // R3
    no_take_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && !clr_i) |-> !pk_q.full);

endmodule

// File: rtl/rxdwb_status.sv
module rxdwb_status
    import rxdwb_pkg::*;
#(
    parameter int LENW = 16
) (
    input  logic [LENW-1:0]   len_i,
    input  logic              long_i,
    input  logic              intr_i,
    output logic [WORD_W-1:0] word_o
);

    logic [LENW-1:0] rec_len;

    always_comb begin
        rec_len = len_i + LENW'(CRC_BYTES);
        word_o  = '0;
        word_o[OWNER_HI:OWNER_LO] = OWNER_CPU;
        word_o[BIT_GOOD]          = 1'b1;
        word_o[BIT_LONG]          = long_i;
        word_o[BIT_INTR]          = intr_i;
        word_o[LENW-1:0]          = rec_len;
    end

endmodule

// File: rtl/rxdwb_engine.sv
module rxdwb_engine
    import rxdwb_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int LENW      = 16,
    parameter int MAX_FRAME = 1518
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_list_base,
    input  logic              cfg_rx_on,
    input  logic              cfg_accept_long,
    input  logic              cfg_rxint_en,
    input  logic              rx_kick,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_last,
    output logic              rx_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic [ADDR_W-1:0] cur_desc_addr,
    output logic              ev_good,
    output logic              ev_too_long,
    output logic              ev_early,
    output logic              ev_unavail,
    output logic              ev_rxint
);

    localparam logic [LENW-1:0]   MAX_L     = LENW'(MAX_FRAME);
    localparam logic [ADDR_W-1:0] OFS_BUF_A = ADDR_W'(OFS_BUFFER);
    localparam logic [ADDR_W-1:0] OFS_LNK_A = ADDR_W'(OFS_LINK);
    localparam int                WSHIFT    = $clog2(WORD_BYTES);

    typedef struct packed {
        rx_state_e       st;
        logic [ADDR_W-1:0] cur;
        logic [ADDR_W-1:0] bufa;
        logic [ADDR_W-1:0] nxt;
        logic [LENW-1:0] widx;
        logic [LENW-1:0] cnt;
        logic            long_f;
        logic            in_frame;
        logic            kick_pend;
        logic            ev_good;
        logic            ev_long;
        logic            ev_early;
        logic            ev_unav;
        logic            ev_int;
    } eng_t;

    eng_t e_d, e_q;

    logic              take;
    logic              pk_take;
    logic              pk_clr;
    logic [WORD_W-1:0] pk_word;
    logic              pk_full;
    logic              pk_last;
    logic [WORD_W-1:0] stat_word;
    logic [LENW-1:0]   cnt_inc;

    rxdwb_packer u_packer (
        .clk    (clk),
        .rst_n  (rst_n),
        .take_i (pk_take),
        .byte_i (rx_data),
        .last_i (rx_last),
        .clr_i  (pk_clr),
        .word_o (pk_word),
        .full_o (pk_full),
        .last_o (pk_last)
    );

    rxdwb_status #(.LENW(LENW)) u_status (
        .len_i  (e_q.cnt),
        .long_i (e_q.long_f),
        .intr_i (cfg_rxint_en),
        .word_o (stat_word)
    );

    assign take    = rx_valid && rx_ready;
    assign cnt_inc = e_q.cnt + 1'b1;

    always_comb begin
        e_d          = e_q;
        e_d.ev_good  = 1'b0;
        e_d.ev_long  = 1'b0;
        e_d.ev_early = 1'b0;
        e_d.ev_unav  = 1'b0;
        e_d.ev_int   = 1'b0;
        rx_ready     = 1'b0;
        mem_req      = 1'b0;
        mem_we       = 1'b0;
        mem_addr     = e_q.cur;
        mem_wdata    = '0;
        pk_take      = 1'b0;
        pk_clr       = 1'b0;

        if (rx_kick) e_d.kick_pend = 1'b1;

        unique case (e_q.st)
            ST_IDLE: begin
                rx_ready = 1'b1;
                if (!cfg_rx_on) begin
                    e_d.cur = cfg_list_base;
                end else if (!e_q.in_frame && !rx_valid) begin
                    e_d.cur = cfg_list_base;
                    e_d.st  = ST_OWN;
                end
            end
            ST_OWN: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    e_d.kick_pend = 1'b0;
                    if (mem_rdata[OWNER_HI:OWNER_LO] == OWNER_ENGINE) begin
                        e_d.st = ST_BUF;
                    end else begin
                        e_d.ev_unav = 1'b1;
                        e_d.st      = ST_STALL;
                    end
                end
            end
            ST_BUF: begin
                mem_req  = 1'b1;
                mem_addr = e_q.cur + OFS_BUF_A;
                if (mem_ack) begin
                    e_d.bufa = mem_rdata[ADDR_W-1:0];
                    e_d.st   = ST_LINK;
                end
            end
            ST_LINK: begin
                mem_req  = 1'b1;
                mem_addr = e_q.cur + OFS_LNK_A;
                if (mem_ack) begin
                    e_d.nxt    = mem_rdata[ADDR_W-1:0];
                    e_d.cnt    = '0;
                    e_d.widx   = '0;
                    e_d.long_f = 1'b0;
                    e_d.st     = ST_RECV;
                end
            end
            ST_RECV: begin
                rx_ready = !pk_full;
                if (pk_full) begin
                    e_d.st = ST_WDATA;
                end else if (take) begin
                    if (cnt_inc > MAX_L) begin
                        if (cfg_accept_long) begin
                            pk_take    = 1'b1;
                            e_d.cnt    = cnt_inc;
                            e_d.long_f = 1'b1;
                        end else begin
                            pk_clr   = 1'b1;
                            e_d.cnt  = '0;
                            e_d.widx = '0;
                            if (rx_last) e_d.ev_long = 1'b1;
                            else         e_d.st      = ST_DROP;
                        end
                    end else begin
                        pk_take = 1'b1;
                        e_d.cnt = cnt_inc;
                    end
                end else if (!cfg_rx_on && !e_q.in_frame) begin
                    e_d.st = ST_IDLE;
                end
            end
            ST_WDATA: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = e_q.bufa + (ADDR_W'(e_q.widx) << WSHIFT);
                mem_wdata = pk_word;
                if (mem_ack) begin
                    pk_clr   = 1'b1;
                    e_d.widx = e_q.widx + 1'b1;
                    if (e_q.widx == '0) e_d.ev_early = 1'b1;
                    e_d.st = pk_last ? ST_WSTAT : ST_RECV;
                end
            end
            ST_WSTAT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = e_q.cur;
                mem_wdata = stat_word;
                if (mem_ack) begin
                    e_d.cur     = e_q.nxt;
                    e_d.ev_good = 1'b1;
                    e_d.ev_int  = cfg_rxint_en;
                    e_d.ev_long = e_q.long_f;
                    e_d.st      = cfg_rx_on ? ST_OWN : ST_IDLE;
                end
            end
            ST_DROP: begin
                rx_ready = 1'b1;
                if (take && rx_last) begin
                    e_d.ev_long = 1'b1;
                    e_d.st      = ST_RECV;
                end
            end
            ST_STALL: begin
                rx_ready = 1'b1;
                if (take && rx_last) begin
                    e_d.ev_unav = 1'b1;
                end else if (!e_q.in_frame && !take) begin
                    if (!cfg_rx_on) begin
                        e_d.st = ST_IDLE;
                    end else if (e_q.kick_pend || rx_kick) begin
                        e_d.kick_pend = 1'b0;
                        e_d.st        = ST_OWN;
                    end
                end
            end
            default: e_d.st = ST_IDLE;
        endcase

        if (take) e_d.in_frame = !rx_last;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q    <= '0;
            e_q.st <= ST_IDLE;
        end else begin
            e_q <= e_d;
        end
    end

    assign cur_desc_addr = e_q.cur;
    assign ev_good       = e_q.ev_good;
    assign ev_too_long   = e_q.ev_long;
    assign ev_early      = e_q.ev_early;
    assign ev_unavail    = e_q.ev_unav;
    assign ev_rxint      = e_q.ev_int;

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R4
    owner_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (e_q.st == ST_WSTAT && mem_req) |-> (mem_we && mem_wdata[OWNER_HI:OWNER_LO] == OWNER_CPU
                                             && mem_wdata[BIT_GOOD]));

    // R6
    ptr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rx_on && $past(cfg_rx_on) && $past(e_q.st) != ST_IDLE && !$stable(cur_desc_addr))
        |-> ev_good);

    // R2
    own_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (e_q.st == ST_OWN && mem_ack && mem_rdata[OWNER_HI:OWNER_LO] != OWNER_ENGINE)
        |=> (ev_unavail && !mem_req));

    // R10
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_rx_on && !$past(cfg_rx_on) && $past(e_q.st) == ST_IDLE) |-> !mem_req);

endmodule

// File: tb/tb_rxdwb_engine.sv
`timescale 1ns/1ps
module tb_rxdwb_engine;

    localparam int MAXF = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_list_base = 32'h100;
    logic        cfg_rx_on = 1'b0;
    logic        cfg_accept_long = 1'b0;
    logic        cfg_rxint_en = 1'b0;
    logic        rx_kick = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = 8'h0;
    logic        rx_last = 1'b0;
    logic        rx_ready;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = 32'h0;
    logic        mem_ack = 1'b0;
    logic [31:0] cur_desc_addr;
    logic        ev_good, ev_too_long, ev_early, ev_unavail, ev_rxint;

    always #2.5 clk = ~clk;

    rxdwb_engine #(.MAX_FRAME(MAXF)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_list_base(cfg_list_base), .cfg_rx_on(cfg_rx_on),
        .cfg_accept_long(cfg_accept_long), .cfg_rxint_en(cfg_rxint_en), .rx_kick(rx_kick),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_ready(rx_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .cur_desc_addr(cur_desc_addr),
        .ev_good(ev_good), .ev_too_long(ev_too_long), .ev_early(ev_early),
        .ev_unavail(ev_unavail), .ev_rxint(ev_rxint)
    );

    // memory model with host write port
    logic [31:0] mem [256];
    logic        hw_en = 1'b0;
    logic [31:0] hw_addr = 32'h0, hw_data = 32'h0;
    int          lat = 0;
    int          wait_c = 0;
    int          n_acc = 0;

    always @(posedge clk) begin
        mem_ack <= 1'b0;
        if (hw_en) mem[hw_addr[9:2]] <= hw_data;
        if (mem_req && !mem_ack) begin
            if (wait_c >= lat) begin
                wait_c  <= 0;
                mem_ack <= 1'b1;
                n_acc   <= n_acc + 1;
                if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
                else        mem_rdata <= mem[mem_addr[9:2]];
            end else begin
                wait_c <= wait_c + 1;
            end
        end
    end

    int c_good = 0, c_long = 0, c_early = 0, c_unav = 0, c_int = 0;
    always @(posedge clk) begin
        if (ev_good)     c_good  <= c_good + 1;
        if (ev_too_long) c_long  <= c_long + 1;
        if (ev_early)    c_early <= c_early + 1;
        if (ev_unavail)  c_unav  <= c_unav + 1;
        if (ev_rxint)    c_int   <= c_int + 1;
    end

    int n_chk = 0, n_err = 0;
    bit done = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic host_wr(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        hw_en = 1'b1; hw_addr = a; hw_data = d;
        @(negedge clk);
        hw_en = 1'b0;
    endtask

    task automatic kick();
        @(negedge clk); rx_kick = 1'b1;
        @(negedge clk); rx_kick = 1'b0;
    endtask

    task automatic settle();
        repeat (80) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic send_frame(input int n, input logic [7:0] seed);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_data  = seed + 8'(i);
            rx_last  = (i == n - 1);
            while (!rx_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        rx_valid = 1'b0;
        rx_last  = 1'b0;
    endtask

    function automatic logic [31:0] wexp(input logic [7:0] seed, input int k0, input int n);
        logic [31:0] w = '0;
        for (int k = 0; k < 4; k++)
            if (k0 + k < n) w[k*8 +: 8] = seed + 8'(k0 + k);
        return w;
    endfunction

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1 mem_req", {31'b0, mem_req}, 32'h0);
        chk("R1 events", {27'b0, ev_good, ev_too_long, ev_early, ev_unavail, ev_rxint}, 32'h0);
        chk("R1 rx_ready", {31'b0, rx_ready}, 32'h1);
        chk("R1 cur", cur_desc_addr, 32'h100);
    endtask

    task automatic t_basic();
        cfg_rxint_en = 1'b1;
        lat = 0;
        cfg_rx_on = 1'b1;
        settle();
        send_frame(5, 8'h10);
        settle();
        chk("R3 word0", mem[8'h80], 32'h13121110);
        chk("R3 partial word", mem[8'h81], 32'h00000014);
        chk("R4 R5 status", mem[8'h40], 32'h00110009);
        chk("R6 cur", cur_desc_addr, 32'h110);
        chk("R6 good", c_good, 1);
        chk("R6 early", c_early, 1);
        chk("R5 rxint", c_int, 1);
    endtask

    task automatic t_long_keep();
        cfg_rxint_en = 1'b0;
        cfg_accept_long = 1'b1;
        lat = 2;
        send_frame(15, 8'h20);
        settle();
        for (int k = 0; k < 4; k++)
            chk("R7 R3 data", mem[8'hA0 + k], wexp(8'h20, 4 * k, 15));
        chk("R7 status", mem[8'h44], 32'h00180013);
        chk("R7 too_long", c_long, 1);
        chk("R7 good", c_good, 2);
        chk("R5 no rxint", c_int, 1);
        chk("R6 cur", cur_desc_addr, 32'h120);
        chk("R2 unavail", c_unav, 1);
    endtask

    task automatic t_stall();
        lat = 0;
        send_frame(3, 8'h30);
        settle();
        chk("R9 unavail per frame", c_unav, 2);
        chk("R9 no store", mem[8'hC0], 32'hDEADBEEF);
        chk("R9 no good", c_good, 2);
        chk("R9 cur", cur_desc_addr, 32'h120);
    endtask

    task automatic t_exact_max();
        cfg_accept_long = 1'b0;
        host_wr(32'h120, 32'h80000000);
        kick();
        settle();
        send_frame(MAXF, 8'h40);
        settle();
        chk("R12 status", mem[8'h48], 32'h00100010);
        chk("R12 no too_long", c_long, 1);
        chk("R12 last word", mem[8'hC2], wexp(8'h40, 8, MAXF));
        chk("R6 cur", cur_desc_addr, 32'h100);
        chk("R2 cpu owned", c_unav, 3);
    endtask

    task automatic t_drop();
        host_wr(32'h100, 32'h80000000);
        kick();
        settle();
        send_frame(14, 8'h60);
        settle();
        chk("R8 too_long", c_long, 2);
        chk("R8 status kept", mem[8'h40], 32'h80000000);
        chk("R8 cur", cur_desc_addr, 32'h100);
        chk("R8 no good", c_good, 3);
        send_frame(4, 8'h50);
        settle();
        chk("R8 reuse data", mem[8'h80], 32'h53525150);
        chk("R8 reuse status", mem[8'h40], 32'h00100008);
        chk("R8 cur after", cur_desc_addr, 32'h110);
    endtask

    task automatic t_off();
        int acc0;
        int g0;
        cfg_rx_on = 1'b0;
        cfg_list_base = 32'h120;
        settle();
        chk("R10 cur tracks base", cur_desc_addr, 32'h120);
        acc0 = n_acc;
        g0 = c_good;
        send_frame(4, 8'h70);
        settle();
        chk("R10 no access", n_acc, acc0);
        chk("R10 no good", c_good, g0);
        chk("R10 rx_ready", {31'b0, rx_ready}, 32'h1);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'hDEADBEEF;
        // desc0 @0x100, desc1 @0x110, desc2 @0x120
        mem[8'h40] = 32'h80000000; mem[8'h41] = 32'h200; mem[8'h43] = 32'h110;
        mem[8'h44] = 32'h80000000; mem[8'h45] = 32'h280; mem[8'h47] = 32'h120;
        mem[8'h48] = 32'h00000000; mem[8'h49] = 32'h300; mem[8'h4B] = 32'h100;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_long_keep();
        t_stall();
        t_exact_max();
        t_drop();
        t_off();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule